// File: doc/BRIEF.md
# Phase Step Controller

This block steers an incremental clock phase shifter to an absolute position that software chooses. Software writes a signed target step count through a single write port. The controller compares that target with its own record of the current position. While the two differ, it sends one single-step command to the shifter, either up or down. It then waits for the shifter to acknowledge the step before it sends another. The current position, the stored target, a busy flag and a sticky stall flag are available for reading.

The shifter works properly only inside a bounded window of steps. If it is driven past that window, its acknowledge becomes erratic or never arrives. For this reason every target is clamped into the window before it is stored. The acknowledge latency can differ from one step to the next, so the controller accepts any delay. A programmable timeout flags an acknowledge that is overdue, but the controller keeps waiting for it.

Top module: `phase_step_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `pos_cur` and `pos_tgt` are 0, and `busy`, `stall` and `step_en` are 0.
- R2: A write (`tgt_wr` high) stores the two's-complement value `tgt_wdata`, clamped to the range -POS_LIMIT..+POS_LIMIT (default 1970). The stored value appears on `pos_tgt` in the cycle after the write.
- R3: `step_en` is a pulse that lasts exactly one cycle. No new pulse is issued until `step_done` has been seen for the previous step.
- R4: The level of `step_inc` in the pulse cycle gives the direction: 1 means up, used when target > position, and 0 means down. `step_inc` does not change while `busy` is high.
- R5: `busy` rises in the cycle `step_en` is high. It stays high through the cycle in which `step_done` is seen and is low in the following cycle.
- R6: `pos_cur` changes only in the cycle after a `step_done` that arrives while `busy` is high. It changes by +1 if `step_inc` is 1 and by -1 otherwise. A `step_done` that arrives while `busy` is low has no effect.
- R7: Once the shifter acknowledges every step, `pos_cur` settles at the clamped target. The number of up and down pulses issued equals the signed distance travelled.
- R8: A target written while a step is outstanding is accepted at once. It steers only the steps issued after the pending acknowledge.
- R9: Count the `step_en` cycle as wait cycle 1. If `step_done` has not arrived by the end of wait cycle `tmo_limit`, `stall` is set. It stays set until reset. Setting `tmo_limit` to 0 disables the check. A late acknowledge is still accepted.
- R10: `pos_cur` never leaves the range -POS_LIMIT..+POS_LIMIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tgt_wr | input | 1 | Target write strobe |
| tgt_wdata | input | POS_W | Signed target step count |
| tmo_limit | input | TMO_W | Acknowledge timeout in cycles; 0 disables the check |
| step_done | input | 1 | Step acknowledge from the shifter |
| step_en | output | 1 | One-cycle step request |
| step_inc | output | 1 | Step direction: 1 up, 0 down |
| busy | output | 1 | A step is outstanding |
| stall | output | 1 | Sticky overdue-acknowledge flag |
| pos_cur | output | POS_W | Signed current position |
| pos_tgt | output | POS_W | Signed stored (clamped) target |

## Verification
The bound checker watches the handshake on every cycle. It confirms that each request is a single-cycle pulse, that no request is issued while one is outstanding, that the direction holds steady during the wait, and that busy drops right after an acknowledge. It also confirms that the position moves by exactly one step, only after an accepted acknowledge, stays inside the window, and that the stall flag never clears by itself. Some behaviour needs the bench's scenarios to show it. These are convergence to clamped targets at both range ends, the exact count and direction of steps, retargeting during an outstanding step, the boundary of the timeout, recovery from an acknowledge that never comes, and stray acknowledges while idle.

// File: rtl/phs_pkg.sv
// Package: shared types for the phase step controller.
// Assumes nothing beyond a two-state sequencer.
package phs_pkg;

    // Sequencer state: idle (no step outstanding) or waiting for acknowledge.
    typedef enum logic {
        PHS_IDLE = 1'b0,
        PHS_WAIT = 1'b1
    } phs_state_e;

endpackage

// File: rtl/phs_target_reg.sv
// Module: phs_target_reg
// Holds the software target position and clamps every written value into
// the symmetric legal window -POS_LIMIT..+POS_LIMIT.
// Assumes POS_LIMIT fits in a positive POS_W-bit two's-complement number.
module phs_target_reg #(
    parameter int POS_W     = 13,
    parameter int POS_LIMIT = 1970
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic signed [POS_W-1:0] wdata,
    output logic signed [POS_W-1:0] tgt
);

    localparam logic signed [POS_W-1:0] LIM_HI = POS_W'(POS_LIMIT);
    localparam logic signed [POS_W-1:0] LIM_LO = -LIM_HI;

    logic signed [POS_W-1:0] clamped;

    // Saturate the written value into the legal window.
    always_comb begin
        if (wdata > LIM_HI) begin
            clamped = LIM_HI;
        end else if (wdata < LIM_LO) begin
            clamped = LIM_LO;
        end else begin
            clamped = wdata;
        end
    end

    // Store the clamped target on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt <= '0;
        end else if (wr) begin
            tgt <= clamped;
        end
    end

endmodule

// File: rtl/phs_step_seq.sv
// Module: phs_step_seq
// Issues single-step requests toward the target, one at a time. The module
// waits for the acknowledge of each step before it looks at the target
// again, and it moves the position record by one step per acknowledge.
// Assumes the target is already inside the legal window.
module phs_step_seq #(
    parameter int POS_W = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [POS_W-1:0] tgt,
    input  logic                    done,
    output logic                    step_en,
    output logic                    step_inc,
    output logic                    busy,
    output logic signed [POS_W-1:0] pos
);

    import phs_pkg::*;

    phs_state_e state_q;

    // Step handshake: issue a pulse, hold the direction, update on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PHS_IDLE;
            pos      <= '0;
            step_en  <= 1'b0;
            step_inc <= 1'b0;
        end else begin
            step_en <= 1'b0;
            case (state_q)
                PHS_IDLE: begin
                    if (tgt != pos) begin
                        step_en  <= 1'b1;
                        step_inc <= (tgt > pos);
                        state_q  <= PHS_WAIT;
                    end
                end
                PHS_WAIT: begin
                    if (done) begin
                        pos     <= step_inc ? pos + POS_W'(1) : pos - POS_W'(1);
                        state_q <= PHS_IDLE;
                    end
                end
                default: state_q <= PHS_IDLE;
            endcase
        end
    end

    // A step is outstanding whenever the sequencer is waiting.
    assign busy = (state_q == PHS_WAIT);

endmodule

// File: rtl/phs_stall_timer.sv
// Module: phs_stall_timer
// Counts wait cycles of the outstanding step. It raises a sticky stall
// flag when the acknowledge is later than the programmed limit.
// Assumes 'waiting' is high from the request cycle through the acknowledge cycle.
module phs_stall_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting,
    input  logic             done,
    input  logic [TMO_W-1:0] limit,
    output logic             stall
);

    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   cnt_next;

    // Cycles waited including the current one.
    assign cnt_next = {1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1};

    // Wait counter: cleared while idle, saturating while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!waiting) begin
            cnt_q <= '0;
        end else if (cnt_q != {TMO_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sticky flag: set when the limit is used up without an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall <= 1'b0;
        end else if (waiting && !done && (limit != '0) &&
                     (cnt_next >= {1'b0, limit})) begin
            stall <= 1'b1;
        end
    end

endmodule

// File: rtl/phase_step_ctrl.sv
// Module: phase_step_ctrl (top)
// Drives an incremental phase shifter to a clamped absolute target through
// a request/acknowledge handshake, one step in flight at a time. It flags
// acknowledges that arrive later than a programmable limit.
// Assumes step_done is a single-cycle pulse from the shifter.
module phase_step_ctrl #(
    parameter int POS_W     = 13,
    parameter int POS_LIMIT = 1970,
    parameter int TMO_W     = 16,
    parameter bit STALL_EN  = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tgt_wr,
    input  logic signed [POS_W-1:0] tgt_wdata,
    input  logic [TMO_W-1:0]        tmo_limit,
    input  logic                    step_done,
    output logic                    step_en,
    output logic                    step_inc,
    output logic                    busy,
    output logic                    stall,
    output logic signed [POS_W-1:0] pos_cur,
    output logic signed [POS_W-1:0] pos_tgt
);

    // Clamped target register.
    phs_target_reg #(
        .POS_W     (POS_W),
        .POS_LIMIT (POS_LIMIT)
    ) u_tgt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (tgt_wr),
        .wdata (tgt_wdata),
        .tgt   (pos_tgt)
    );

    // Step sequencer.
    phs_step_seq #(
        .POS_W (POS_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt      (pos_tgt),
        .done     (step_done),
        .step_en  (step_en),
        .step_inc (step_inc),
        .busy     (busy),
        .pos      (pos_cur)
    );

    // Optional overdue-acknowledge detection.
    generate
        if (STALL_EN) begin : g_stall
            phs_stall_timer #(
                .TMO_W (TMO_W)
            ) u_tmo (
                .clk     (clk),
                .rst_n   (rst_n),
                .waiting (busy),
                .done    (step_done),
                .limit   (tmo_limit),
                .stall   (stall)
            );
        end else begin : g_no_stall
            logic unused_tmo;
            assign unused_tmo = ^tmo_limit;
            assign stall      = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/phs_ctrl_chk.sv
// Module: phs_ctrl_chk
// Cycle-by-cycle protocol checker for phase_step_ctrl, attached by bind.
// Assumes the synchronous active-low reset is held for at least one edge.
module phs_ctrl_chk #(
    parameter int POS_W     = 13,
    parameter int POS_LIMIT = 1970
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    step_done,
    input logic                    step_en,
    input logic                    step_inc,
    input logic                    busy,
    input logic                    stall,
    input logic signed [POS_W-1:0] pos_cur,
    input logic signed [POS_W-1:0] pos_tgt
);

    localparam logic signed [POS_W-1:0] LIM_HI = POS_W'(POS_LIMIT);
    localparam logic signed [POS_W-1:0] LIM_LO = -LIM_HI;

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> !step_en);

    assert_no_issue_in_flight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_done) |=> !step_en);

    assert_dir_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_done) |=> $stable(step_inc));

    assert_busy_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> busy);

    assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step_done) |=> !busy);

    assert_pos_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && step_done) |=> $stable(pos_cur));

    assert_pos_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step_done) |=>
        (pos_cur == ($past(step_inc) ? $past(pos_cur) + POS_W'(1)
                                     : $past(pos_cur) - POS_W'(1))));

    assert_tgt_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_tgt <= LIM_HI) && (pos_tgt >= LIM_LO));

    assert_pos_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_cur <= LIM_HI) && (pos_cur >= LIM_LO));

    assert_stall_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> stall);

endmodule

bind phase_step_ctrl phs_ctrl_chk #(
    .POS_W     (POS_W),
    .POS_LIMIT (POS_LIMIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_done (step_done),
    .step_en   (step_en),
    .step_inc  (step_inc),
    .busy      (busy),
    .stall     (stall),
    .pos_cur   (pos_cur),
    .pos_tgt   (pos_tgt)
);

// File: tb/sim_phase_step_ctrl.sv
module sim_phase_step_ctrl;

    localparam int POS_W = 13;
    localparam int TMO_W = 16;
    localparam int NVEC  = 7;

    // Table: written target, acknowledge delay, expected settle, ups, downs.
    localparam int TBL_TGT[NVEC]  = '{5, -3, 2500, -4096, 0, 1970, 1969};
    localparam int TBL_DLY[NVEC]  = '{1,  3,    1,     2, 4,    1,    2};
    localparam int TBL_POS[NVEC]  = '{5, -3, 1970, -1970, 0, 1970, 1969};
    localparam int TBL_UP[NVEC]   = '{5,  0, 1973,     0, 1970, 1970, 0};
    localparam int TBL_DN[NVEC]   = '{0,  8,    0,  3940, 0,    0,    1};

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    tgt_wr = 1'b0;
    logic signed [POS_W-1:0] tgt_wdata = '0;
    logic [TMO_W-1:0]        tmo_limit = '0;
    logic                    step_done;
    logic                    step_en, step_inc, busy, stall;
    logic signed [POS_W-1:0] pos_cur, pos_tgt;

    logic resp_done = 1'b0;
    logic man_done = 1'b0;
    int   resp_dly = 1;
    bit   resp_off = 1'b0;
    int   resp_cnt = 0;
    int   n_up = 0;
    int   n_dn = 0;
    int   checks = 0;
    int   fails = 0;

    assign step_done = resp_done | man_done;

    always #2.5 clk = ~clk;

    phase_step_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgt_wr    (tgt_wr),
        .tgt_wdata (tgt_wdata),
        .tmo_limit (tmo_limit),
        .step_done (step_done),
        .step_en   (step_en),
        .step_inc  (step_inc),
        .busy      (busy),
        .stall     (stall),
        .pos_cur   (pos_cur),
        .pos_tgt   (pos_tgt)
    );

    // Behavioural shifter: acknowledge resp_dly cycles after the request cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            resp_cnt  <= 0;
            resp_done <= 1'b0;
        end else begin
            resp_done <= 1'b0;
            if (resp_cnt > 0) begin
                resp_cnt <= resp_cnt - 1;
                if (resp_cnt == 1) resp_done <= 1'b1;
            end
            if (step_en && !resp_off) resp_cnt <= resp_dly;
        end
    end

    // Count issued requests by direction.
    always @(negedge clk) begin
        if (rst_n && step_en) begin
            if (step_inc) n_up <= n_up + 1;
            else          n_dn <= n_dn + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_tgt(input int v);
        tgt_wr    = 1'b1;
        tgt_wdata = POS_W'(v);
        @(negedge clk);
        tgt_wr    = 1'b0;
    endtask

    task automatic settle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (!busy) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk_reset_state();
        chk(pos_cur == 0, "R1 pos_cur", int'(pos_cur), 0);
        chk(pos_tgt == 0, "R1 pos_tgt", int'(pos_tgt), 0);
        chk(!busy,   "R1 busy",  int'(busy), 0);
        chk(!stall,  "R1 stall", int'(stall), 0);
        chk(!step_en, "R1 step_en", int'(step_en), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int up0, dn0, p0;
        do_reset();
        chk_reset_state();

        // Table walk: R2 clamp, R7 convergence and step counts.
        for (int i = 0; i < NVEC; i++) begin
            resp_dly = TBL_DLY[i];
            up0 = n_up;
            dn0 = n_dn;
            write_tgt(TBL_TGT[i]);
            chk(int'(pos_tgt) == TBL_POS[i], "R2 clamped target", int'(pos_tgt), TBL_POS[i]);
            settle();
            chk(int'(pos_cur) == TBL_POS[i], "R7 settled position", int'(pos_cur), TBL_POS[i]);
            chk(n_up - up0 == TBL_UP[i], "R7 up steps", n_up - up0, TBL_UP[i]);
            chk(n_dn - dn0 == TBL_DN[i], "R7 down steps", n_dn - dn0, TBL_DN[i]);
        end
        chk(!stall, "R9 disabled when limit 0", int'(stall), 0);

        // R1: reset after movement returns to zero.
        do_reset();
        chk_reset_state();

        // R3/R4/R5/R6 exact handshake timing, delay 3.
        resp_dly = 3;
        write_tgt(1);
        chk(!step_en, "R3 no request yet", int'(step_en), 0);
        @(negedge clk);
        chk(step_en && busy, "R5 busy with request", int'(busy), 1);
        chk(step_inc, "R4 up direction", int'(step_inc), 1);
        @(negedge clk);
        chk(!step_en, "R3 single pulse", int'(step_en), 0);
        chk(busy, "R5 busy while waiting", int'(busy), 1);
        @(negedge clk);
        @(negedge clk);
        chk(busy, "R5 busy in acknowledge cycle", int'(busy), 1);
        chk(pos_cur == 0, "R6 no move before acknowledge", int'(pos_cur), 0);
        @(negedge clk);
        chk(!busy, "R5 busy low after acknowledge", int'(busy), 0);
        chk(pos_cur == 1, "R6 move after acknowledge", int'(pos_cur), 1);
        settle();
        chk(pos_cur == 1, "R7 holds at target", int'(pos_cur), 1);

        // R8: retarget while a step is outstanding.
        resp_dly = 6;
        up0 = n_up;
        dn0 = n_dn;
        write_tgt(2);
        @(negedge clk);
        @(negedge clk);
        write_tgt(-1);
        chk(pos_tgt == -1, "R8 new target accepted", int'(pos_tgt), -1);
        chk(pos_cur == 1 && busy, "R8 pending step still waiting", int'(pos_cur), 1);
        settle();
        chk(pos_cur == -1, "R8 final position", int'(pos_cur), -1);
        chk(n_up - up0 == 1, "R8 pending up step kept", n_up - up0, 1);
        chk(n_dn - dn0 == 3, "R8 down steps after", n_dn - dn0, 3);

        // R6: a stray acknowledge while idle is ignored.
        p0 = int'(pos_cur);
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
        repeat (3) @(negedge clk);
        chk(int'(pos_cur) == p0, "R6 stray acknowledge ignored", int'(pos_cur), p0);
        chk(!busy && !step_en, "R6 stray acknowledge no request", int'(busy), 0);

        // R9 boundary: done in wait cycle 5 with limit 5 is on time.
        tmo_limit = 16'd5;
        resp_dly = 4;
        write_tgt(0);
        settle();
        chk(!stall, "R9 on-time acknowledge", int'(stall), 0);
        resp_dly = 5;
        write_tgt(1);
        settle();
        chk(stall, "R9 late acknowledge flags stall", int'(stall), 1);
        chk(pos_cur == 1, "R9 late acknowledge accepted", int'(pos_cur), 1);
        resp_dly = 1;
        write_tgt(2);
        settle();
        chk(stall, "R9 stall sticky", int'(stall), 1);

        // R9: missing acknowledge, controller waits, recovers on a late done.
        do_reset();
        chk_reset_state();
        tmo_limit = 16'd5;
        resp_off = 1'b1;
        up0 = n_up;
        write_tgt(3);
        repeat (20) @(negedge clk);
        chk(busy && stall, "R9 stalled and waiting", int'(stall), 1);
        chk(n_up - up0 == 1, "R3 one request while stalled", n_up - up0, 1);
        chk(pos_cur == 0, "R6 no move without acknowledge", int'(pos_cur), 0);
        resp_off = 1'b0;
        resp_dly = 1;
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
        chk(pos_cur == 1 && !busy, "R9 late done accepted", int'(pos_cur), 1);
        settle();
        chk(pos_cur == 3, "R7 resumes to target", int'(pos_cur), 3);
        chk(stall, "R9 stall kept until reset", int'(stall), 1);
        do_reset();
        chk(!stall, "R1 reset clears stall", int'(stall), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule